// File: doc/BRIEF.md
# Streaming Box Filter

This block smooths a stream of pixels along one image line with a moving average over a window of `WIN` samples. Rather than summing all window samples for every output, it keeps a running total: each accepted sample is added in, and the sample that falls out of the window is taken off. A circular history of the last `WIN` samples supplies that departing value. The total is then scaled by a fixed-point reciprocal of `WIN` and rounded. The work per output is one add, one subtract and one multiply, whatever the window width.

Pixels arrive and leave on valid/ready handshakes. A flag that travels with an input sample marks the first pixel of a new line. It restarts the window, so pixels from the previous line never mix into the new one. Outputs begin once a line has supplied `WIN` samples. A 2D box is built from two such passes, one per axis. Smoother responses come from running the same pass two or three times in a row. The history can be built as rotating registers or as a ring buffer with a wrapping pointer, chosen by a parameter.

Top module: `box_stream_filter`

## Requirements
- R1: During and right after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The first `WIN`-1 samples accepted after a line start produce no output.
- R3: Every output equals `min(2^DATA_W-1, (S*K + 2^(FRAC_W-1)) >> FRAC_W)`. Here `S` is the sum of the last `WIN` samples accepted in the current line and `K = (2^FRAC_W + WIN/2) / WIN` (integer division).
- R4: The output for a sample that fills or slides the window is valid on the clock edge that follows the edge at which that sample was accepted.
- R5: A sample accepted with `in_line_start` high begins a new window. No sample from an earlier line contributes to any later output.
- R6: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `out_valid`, `out_data` and `out_line_first` hold their values.
- R7: Each accepted sample that completes a window yields exactly one output, in input order. No output appears without such a sample.
- R8: `out_line_first` is 1 on the first output of each line and 0 on every other output.
- R9: The rotating-register history (`HIST_ROTATE`=1) and the ring-buffer history (`HIST_ROTATE`=0) give identical outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | DATA_W | Input pixel, unsigned |
| in_line_start | input | 1 | Sample is the first of a line |
| out_valid | output | 1 | Filtered pixel present |
| out_ready | input | 1 | Downstream takes the pixel this cycle |
| out_data | output | DATA_W | Filtered pixel, unsigned |
| out_line_first | output | 1 | Pixel is the first output of its line |

## Verification
A filtered pixel is due one clock edge after the input sample that completes its window is accepted. It then stays put for as long as `out_ready` holds it back. The bench drives inputs on the falling edge and reads every output 1 ns later. It decides acceptance and consumption from the values it sees at that moment. When a sample is accepted, the bench computes the expected result from a direct sum over its own copy of the line and queues it. On the next sampling point the bench requires that result at the head of the output. A second instance with a wider window and the other history style follows the same input stream and has its own model.

// File: rtl/box_filter_pkg.sv
package box_filter_pkg;

    // Fixed-point reciprocal of the window length, rounded to nearest.
    function automatic int recip_of(input int win, input int frac);
        return ((1 << frac) + win / 2) / win;
    endfunction

endpackage

// File: rtl/box_history.sv
// Keeps the last DEPTH pushed samples; 'oldest' is the one a new push evicts.
module box_history #(
    parameter int DATA_W  = 8,
    parameter int DEPTH   = 4,
    parameter bit ROTATE  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] oldest
);

    generate
        if (ROTATE) begin : g_rotate
            logic [DATA_W-1:0] sr_d [DEPTH];
            logic [DATA_W-1:0] sr_q [DEPTH];

            always_comb begin
                for (int i = 0; i < DEPTH; i++) sr_d[i] = sr_q[i];
                if (push) begin
                    sr_d[0] = din;
                    for (int i = 1; i < DEPTH; i++) sr_d[i] = sr_q[i-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) sr_q[i] <= '0;
                end else begin
                    for (int i = 0; i < DEPTH; i++) sr_q[i] <= sr_d[i];
                end
            end

            assign oldest = sr_q[DEPTH-1];
        end else begin : g_ring
            localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
            localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

            logic [DATA_W-1:0] mem_q [DEPTH];
            logic [PTR_W-1:0]  ptr_d, ptr_q;

            always_comb begin
                ptr_d = ptr_q;
                if (push) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + PTR_W'(1);
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ptr_q <= '0;
                    for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
                end else begin
                    ptr_q <= ptr_d;
                    if (push) mem_q[ptr_q] <= din;
                end
            end

            assign oldest = mem_q[ptr_q];
        end
    endgenerate

endmodule

// File: rtl/box_scale.sv
// Multiplies the window sum by a fixed-point reciprocal, rounds and clamps.
module box_scale #(
    parameter int SUM_W  = 10,
    parameter int DATA_W = 8,
    parameter int FRAC_W = 16,
    parameter int RECIP  = 16384
) (
    input  logic [SUM_W-1:0]  sum,
    output logic [DATA_W-1:0] avg
);

    localparam int PROD_W = SUM_W + FRAC_W + 1;
    localparam logic [PROD_W-1:0] HALF = PROD_W'(1) << (FRAC_W - 1);
    localparam logic [PROD_W-1:0] TOP  = PROD_W'({DATA_W{1'b1}});

    logic [PROD_W-1:0] prod_d;
    logic [PROD_W-1:0] shifted_d;

    always_comb begin
        prod_d    = PROD_W'(sum) * PROD_W'(RECIP) + HALF;
        shifted_d = prod_d >> FRAC_W;
        avg       = (shifted_d > TOP) ? {DATA_W{1'b1}} : shifted_d[DATA_W-1:0];
    end

endmodule

// File: rtl/box_stream_filter.sv
module box_stream_filter #(
    parameter int DATA_W      = 8,
    parameter int WIN         = 4,
    parameter int FRAC_W      = 16,
    parameter bit HIST_ROTATE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_line_start,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_line_first
);

    localparam int GUARD_W = $clog2(WIN);
    localparam int SUM_W   = DATA_W + GUARD_W;
    localparam int CNT_W   = $clog2(WIN + 1);
    localparam int RECIP   = box_filter_pkg::recip_of(WIN, FRAC_W);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WIN);
    localparam logic [CNT_W-1:0] NEAR = CNT_W'(WIN - 1);

    typedef struct packed {
        logic [SUM_W-1:0]  sum;
        logic [CNT_W-1:0]  fill;
        logic              ov;
        logic [DATA_W-1:0] od;
        logic              first;
    } state_t;

    state_t s_d, s_q;

    logic              accept;
    logic              full_before;
    logic [SUM_W-1:0]  base_sum;
    logic [SUM_W-1:0]  next_sum;
    logic [CNT_W-1:0]  base_fill;
    logic [DATA_W-1:0] leaving;
    logic [DATA_W-1:0] oldest;
    logic [DATA_W-1:0] scaled;

    assign in_ready = !s_q.ov || out_ready;
    assign accept   = in_valid && in_ready;

    box_history #(
        .DATA_W (DATA_W),
        .DEPTH  (WIN),
        .ROTATE (HIST_ROTATE)
    ) u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (accept),
        .din    (in_data),
        .oldest (oldest)
    );

    box_scale #(
        .SUM_W  (SUM_W),
        .DATA_W (DATA_W),
        .FRAC_W (FRAC_W),
        .RECIP  (RECIP)
    ) u_scale (
        .sum (next_sum),
        .avg (scaled)
    );

    always_comb begin
        base_sum    = in_line_start ? '0 : s_q.sum;
        base_fill   = in_line_start ? '0 : s_q.fill;
        full_before = (base_fill == FULL);
        leaving     = full_before ? oldest : '0;
        next_sum    = base_sum + SUM_W'(in_data) - SUM_W'(leaving);

        s_d = s_q;
        if (s_q.ov && out_ready) s_d.ov = 1'b0;
        if (accept) begin
            s_d.sum  = next_sum;
            s_d.fill = full_before ? base_fill : base_fill + CNT_W'(1);
            if (full_before || base_fill == NEAR) begin
                s_d.ov    = 1'b1;
                s_d.od    = scaled;
                s_d.first = !full_before;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid      = s_q.ov;
    assign out_data       = s_q.od;
    assign out_line_first = s_q.first;

endmodule

// File: rtl/box_stream_filter_chk.sv
module box_stream_filter_chk #(
    parameter int DATA_W = 8,
    parameter int WIN    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_line_start,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_line_first
);

    int   seen_q;
    logic acc;
    logic completes;
    logic is_first;

    assign acc       = in_valid && in_ready;
    assign completes = in_line_start ? (WIN == 1) : (seen_q >= WIN - 1);
    assign is_first  = in_line_start ? (WIN == 1) : (seen_q == WIN - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             seen_q <= 0;
        else if (acc) begin
            if (in_line_start)   seen_q <= 1;
            else if (seen_q < WIN) seen_q <= seen_q + 1;
        end
    end

    assert_no_early_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !completes |=> !out_valid);

    assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc && completes |=> out_valid);

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_line_first));

    assert_no_phantom_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !acc && !(out_valid && !out_ready) |=> !out_valid);

    assert_first_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc && completes |=> out_line_first == $past(is_first));

endmodule

bind box_stream_filter box_stream_filter_chk #(
    .DATA_W (DATA_W),
    .WIN    (WIN)
) u_chk (.*);

// File: tb/box_stream_filter_test.sv
`timescale 1ns/1ps
module box_stream_filter_test;

    localparam int WA = 4;
    localparam int WB = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_sol = 1'b0;
    logic [7:0] in_data = '0;
    logic       a_ordy = 1'b1;
    logic       a_irdy, a_ov, a_first;
    logic [7:0] a_od;
    logic       b_valid;
    logic       b_irdy, b_ov, b_first;
    logic [7:0] b_od;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    assign b_valid = in_valid && a_irdy;

    box_stream_filter #(.DATA_W(8), .WIN(WA), .FRAC_W(16), .HIST_ROTATE(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(a_irdy),
        .in_data(in_data), .in_line_start(in_sol), .out_valid(a_ov),
        .out_ready(a_ordy), .out_data(a_od), .out_line_first(a_first));

    box_stream_filter #(.DATA_W(8), .WIN(WB), .FRAC_W(16), .HIST_ROTATE(1'b1)) uut_b (
        .clk(clk), .rst_n(rst_n), .in_valid(b_valid), .in_ready(b_irdy),
        .in_data(in_data), .in_line_start(in_sol), .out_valid(b_ov),
        .out_ready(1'b1), .out_data(b_od), .out_line_first(b_first));

    // {line_start, data, expect_valid, expect_data} for the WIN=4 instance
    localparam logic [17:0] VEC [16] = '{
        {1'b1, 8'd4,   1'b0, 8'd0},   {1'b0, 8'd8,   1'b0, 8'd0},
        {1'b0, 8'd12,  1'b0, 8'd0},   {1'b0, 8'd16,  1'b1, 8'd10},
        {1'b0, 8'd20,  1'b1, 8'd14},  {1'b0, 8'd1,   1'b1, 8'd12},
        {1'b1, 8'd255, 1'b0, 8'd0},   {1'b0, 8'd255, 1'b0, 8'd0},
        {1'b0, 8'd255, 1'b0, 8'd0},   {1'b0, 8'd255, 1'b1, 8'd255},
        {1'b0, 8'd0,   1'b1, 8'd191}, {1'b0, 8'd2,   1'b1, 8'd128},
        {1'b1, 8'd3,   1'b0, 8'd0},   {1'b0, 8'd3,   1'b0, 8'd0},
        {1'b0, 8'd3,   1'b0, 8'd0},   {1'b0, 8'd5,   1'b1, 8'd4}
    };

    int  line_a[$], line_b[$];
    int  qa_d[$], qa_f[$], qb_d[$], qb_f[$];
    bit  push_a_last = 1'b0, push_b_last = 1'b0;
    bit  obs_v;
    int  obs_d;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model_avg(input int sum, input int win);
        int k;
        int v;
        k = ((1 << 16) + win / 2) / win;
        v = (sum * k + 32768) >>> 16;
        return (v > 255) ? 255 : v;
    endfunction

    function automatic int tail_sum(input int line[$], input int win);
        int s = 0;
        for (int i = line.size() - win; i < line.size(); i++) s += line[i];
        return s;
    endfunction

    task automatic step(input bit v, input bit sol, input int d, input bit ordy);
        bit acc;
        @(negedge clk);
        in_valid = v; in_sol = sol; in_data = 8'(d); a_ordy = ordy;
        #1;
        obs_v = a_ov; obs_d = a_od;
        // instance A
        if (push_a_last) check(a_ov == 1'b1, "R4", a_ov, 1);
        check(a_ov == (qa_d.size() != 0), "R7", a_ov, qa_d.size() != 0);
        if (a_ov && qa_d.size() != 0) begin
            check(a_od == qa_d[0], "R3", a_od, qa_d[0]);
            check(a_first == qa_f[0], "R8", a_first, qa_f[0]);
        end
        if (a_ov && !ordy) check(a_irdy == 1'b0, "R6", a_irdy, 0);
        if (a_ov && ordy && qa_d.size() != 0) begin
            void'(qa_d.pop_front()); void'(qa_f.pop_front());
        end
        // instance B: rotating history, always ready downstream
        if (push_b_last) check(b_ov == 1'b1, "R4", b_ov, 1);
        check(b_ov == (qb_d.size() != 0), "R9", b_ov, qb_d.size() != 0);
        if (b_ov && qb_d.size() != 0) begin
            check(b_od == qb_d[0], "R9", b_od, qb_d[0]);
            check(b_first == qb_f[0], "R8", b_first, qb_f[0]);
            void'(qb_d.pop_front()); void'(qb_f.pop_front());
        end
        check(b_irdy == 1'b1, "R9", b_irdy, 1);
        acc = v && a_irdy;
        push_a_last = 1'b0; push_b_last = 1'b0;
        if (acc) begin
            if (sol) begin line_a.delete(); line_b.delete(); end
            line_a.push_back(d); line_b.push_back(d);
            if (line_a.size() >= WA) begin
                qa_d.push_back(model_avg(tail_sum(line_a, WA), WA));
                qa_f.push_back(line_a.size() == WA);
                push_a_last = 1'b1;
            end
            if (line_b.size() >= WB) begin
                qb_d.push_back(model_avg(tail_sum(line_b, WB), WB));
                qb_f.push_back(line_b.size() == WB);
                push_b_last = 1'b1;
            end
        end
    endtask

    initial begin
        int run_len;
        // R1: reset state
        repeat (2) @(negedge clk);
        #1;
        check(a_ov == 1'b0, "R1", a_ov, 0);
        check(a_irdy == 1'b1, "R1", a_irdy, 1);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(a_ov == 1'b0 && b_ov == 1'b0, "R1", a_ov, 0);
        check(a_irdy == 1'b1, "R1", a_irdy, 1);

        // table walk, one vector per cycle, output checked one cycle later
        for (int i = 0; i <= 16; i++) begin
            if (i < 16) step(1'b1, VEC[i][17], int'(VEC[i][16:9]), 1'b1);
            else        step(1'b0, 1'b0, 0, 1'b1);
            if (i > 0) begin
                check(obs_v == VEC[i-1][8], "R2", obs_v, VEC[i-1][8]);
                if (VEC[i-1][8]) check(obs_d == int'(VEC[i-1][7:0]), "R3/R5", obs_d, VEC[i-1][7:0]);
            end
        end

        // directed R6: hold output back for several cycles mid-line
        step(1'b1, 1'b1, 40, 1'b1);
        for (int i = 0; i < WA; i++) step(1'b1, 1'b0, 60 + i, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 90, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 0, 1'b1);

        // random lines with random gaps and backpressure
        run_len = 0;
        for (int c = 0; c < 1500; c++) begin
            bit v;
            bit sol;
            v   = ($urandom % 10) < 8;
            sol = 1'b0;
            if (v && (run_len == 0 || ($urandom % 12) == 0)) begin
                sol = 1'b1;
                run_len = 1 + ($urandom % 14);
            end
            if (v && run_len > 0) run_len--;
            step(v, sol, ($urandom % 4 == 0) ? 255 : int'($urandom % 256), ($urandom % 10) < 7);
        end

        // drain
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 0, 1'b1);
        check(qa_d.size() == 0, "R7", qa_d.size(), 0);
        check(qb_d.size() == 0, "R9", qb_d.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule